// File: doc/BRIEF.md
# Network Device Power-State Controller

This block keeps the power state of a network-interface function on a PCI-style bus. The state set is D0 uninitialized, D0 active, D1, D2, D3 hot and D3 cold. Configuration writes move the block between states. Programming a base address register brings it out of the uninitialized substate. A power-loss input pushes D3 hot into D3 cold, and the return of main power restarts the block in the uninitialized substate.

The current state decides three things. It gates ordinary bus transactions. It decides which wake sources (link-status change, wake-packet match) latch a sticky, active-low power-management-event indication. It also decides when the block drives its active-low clock-run request, which keeps the host from stopping the bus clock or asks the host to restore it. Software can turn clock-run control off. The block then claims the bus clock permanently.

Top module: `nic_pwr_ctl`

## Requirements
- R1: While reset is held and after its release, `pwr_state` reads 0 (D0 uninitialized), `txn_en` is 1, `pme_n` is 1 and `clkrun_n` is 1. The clock-run control starts out enabled.
- R2: In D0 uninitialized, an accepted config write to one of the three base address registers (addresses 0x10, 0x14, 0x18) moves `pwr_state` to 1 (D0 active) at the next clock edge. A write to any other address leaves the state unchanged.
- R3: A config write to the power-control register (address 0x44) selects the state from data bits [1:0]. 01 selects D1 (code 2), 10 selects D2 (code 3) and 11 selects D3 hot (code 4). 00 selects D0 active (code 1), except that from D0 uninitialized it leaves the state at 0. The new state shows at the next clock edge.
- R4: `txn_en` is 1 exactly when `pwr_state` is 0 or 1 (a D0 substate), and 0 in every other state.
- R5: In D3 hot (code 4) with `main_pwr_ok` low, the state becomes D3 cold (code 5) at the next edge. In D3 cold, `main_pwr_ok` high moves the state to 0 at the next edge. All config writes are ignored while in D3 cold.
- R6: In D1, D2 or D3 hot, a `link_chg` or `wake_pkt` pulse drives `pme_n` low from the next edge.
- R7: In D0 active only `link_chg` sets the event, and `wake_pkt` has no effect. In D0 uninitialized neither pulse has any effect.
- R8: In D3 cold a wake pulse sets the event only while `aux_pwr` is 1.
- R9: `pme_n` stays low until an accepted power-control write with data bit 7 set. A state change back to D0 does not clear it. A qualifying wake in the same cycle as the clear wins, and `pme_n` stays low.
- R10: With clock-run enabled (power-control data bit 2 = 1), `clkrun_n` goes low one edge after a cycle in D0 active with both `clk_stop_req` and `link_busy` high. It is high after any other cycle.
- R11: Each power-control write loads the clock-run enable from data bit 2. When it is 0, `clkrun_n` is low in every state from the second edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cfg_wr | input | 1 | Configuration write strobe, one cycle per write |
| cfg_addr | input | 8 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| link_chg | input | 1 | Link-status-change pulse |
| wake_pkt | input | 1 | Wake-packet-match pulse |
| aux_pwr | input | 1 | Auxiliary power present |
| main_pwr_ok | input | 1 | Main power present; low in D3 hot means power removed |
| clk_stop_req | input | 1 | Host asks to stop the bus clock |
| link_busy | input | 1 | Transmit or receive activity in progress |
| pwr_state | output | 3 | Current state: 0 D0u, 1 D0a, 2 D1, 3 D2, 4 D3hot, 5 D3cold |
| txn_en | output | 1 | Ordinary bus transactions accepted |
| pme_n | output | 1 | Active-low power-management event |
| clkrun_n | output | 1 | Active-low clock-run drive |

## Verification
State changes and the power-management event are due at the first clock edge after the stimulus cycle. `txn_en` follows the state with no further delay. The clock-run drive is due one edge after the cycle whose state and inputs it reflects, so it lags a clock-run enable change by two edges. The bench drives inputs on falling edges and runs a behavioural model on rising edges. It compares every output a few nanoseconds after each rising edge. Directed checks sample on the falling edge after the relevant rising edge, which matches those latencies.

// File: rtl/nic_pwr_pkg.sv
package nic_pwr_pkg;

    typedef enum logic [2:0] {
        PS_D0U = 3'd0,
        PS_D0A = 3'd1,
        PS_D1  = 3'd2,
        PS_D2  = 3'd3,
        PS_D3H = 3'd4,
        PS_D3C = 3'd5
    } pstate_e;

    localparam int CFG_AW_DEF      = 8;
    localparam int CFG_DW_DEF      = 8;
    localparam int NUM_BARS_DEF    = 3;
    localparam int BAR_BASE_DEF    = 'h10;
    localparam int BAR_STRIDE_DEF  = 4;
    localparam int PMCTL_ADDR_DEF  = 'h44;
    localparam int STATE_LSB_DEF   = 0;
    localparam int CKR_EN_BIT_DEF  = 2;
    localparam int PME_CLR_BIT_DEF = 7;

endpackage

// File: rtl/nic_pwr_cfg_dec.sv
module nic_pwr_cfg_dec #(
    parameter int AW         = 8,
    parameter int NUM_BARS   = 3,
    parameter int BAR_BASE   = 'h10,
    parameter int BAR_STRIDE = 4,
    parameter int PMCTL_ADDR = 'h44
) (
    input  logic          wr_ok,
    input  logic [AW-1:0] addr,
    output logic          bar_wr,
    output logic          pm_wr
);
    logic [NUM_BARS-1:0] hit;

    for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
        localparam logic [AW-1:0] BAR_ADDR = AW'(BAR_BASE + i * BAR_STRIDE);
        assign hit[i] = (addr == BAR_ADDR);
    end

    assign bar_wr = wr_ok && (|hit);
    assign pm_wr  = wr_ok && (addr == AW'(PMCTL_ADDR));
endmodule

// File: rtl/nic_pwr_wake.sv
module nic_pwr_wake
    import nic_pwr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  pstate_e state,
    input  logic    link_chg,
    input  logic    wake_pkt,
    input  logic    aux_pwr,
    input  logic    clr,
    output logic    pme_n
);
    typedef struct packed {
        logic pme;
    } wake_t;

    wake_t q, d;
    logic  qual;

    always_comb begin
        unique case (state)
            PS_D0U:                qual = 1'b0;
            PS_D0A:                qual = link_chg;
            PS_D1, PS_D2, PS_D3H:  qual = link_chg | wake_pkt;
            PS_D3C:                qual = (link_chg | wake_pkt) & aux_pwr;
            default:               qual = 1'b0;
        endcase
        d = q;
        if (qual)     d.pme = 1'b1;
        else if (clr) d.pme = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pme_n = ~q.pme;
endmodule

// File: rtl/nic_pwr_clkrun.sv
module nic_pwr_clkrun (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic en_wr,
    input  logic en_val,
    input  logic stop_req,
    input  logic busy,
    output logic clkrun_n
);
    typedef struct packed {
        logic en;
        logic drv;
    } ckr_t;

    ckr_t q, d;

    always_comb begin
        d     = q;
        d.en  = en_wr ? en_val : q.en;
        d.drv = !q.en || (active && stop_req && busy);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.en  <= 1'b1;
            q.drv <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign clkrun_n = ~q.drv;
endmodule

// File: rtl/nic_pwr_ctl.sv
module nic_pwr_ctl
    import nic_pwr_pkg::*;
#(
    parameter int CFG_AW      = CFG_AW_DEF,
    parameter int CFG_DW      = CFG_DW_DEF,
    parameter int NUM_BARS    = NUM_BARS_DEF,
    parameter int BAR_BASE    = BAR_BASE_DEF,
    parameter int BAR_STRIDE  = BAR_STRIDE_DEF,
    parameter int PMCTL_ADDR  = PMCTL_ADDR_DEF,
    parameter int STATE_LSB   = STATE_LSB_DEF,
    parameter int CKR_EN_BIT  = CKR_EN_BIT_DEF,
    parameter int PME_CLR_BIT = PME_CLR_BIT_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    input  logic              link_chg,
    input  logic              wake_pkt,
    input  logic              aux_pwr,
    input  logic              main_pwr_ok,
    input  logic              clk_stop_req,
    input  logic              link_busy,
    output logic [2:0]        pwr_state,
    output logic              txn_en,
    output logic              pme_n,
    output logic              clkrun_n
);
    localparam int SEL_W = 2;

    typedef struct packed {
        pstate_e st;
    } fsm_t;

    fsm_t             q, d;
    logic             wr_ok, bar_wr, pm_wr;
    logic [SEL_W-1:0] sel;
    pstate_e          sel_st;

    assign wr_ok = cfg_wr && (q.st != PS_D3C);
    assign sel   = cfg_wdata[STATE_LSB +: SEL_W];

    nic_pwr_cfg_dec #(
        .AW(CFG_AW), .NUM_BARS(NUM_BARS), .BAR_BASE(BAR_BASE),
        .BAR_STRIDE(BAR_STRIDE), .PMCTL_ADDR(PMCTL_ADDR)
    ) u_dec (
        .wr_ok (wr_ok),
        .addr  (cfg_addr),
        .bar_wr(bar_wr),
        .pm_wr (pm_wr)
    );

    always_comb begin
        unique case (sel)
            2'b00:   sel_st = (q.st == PS_D0U) ? PS_D0U : PS_D0A;
            2'b01:   sel_st = PS_D1;
            2'b10:   sel_st = PS_D2;
            default: sel_st = PS_D3H;
        endcase
    end

    always_comb begin
        d = q;
        unique case (q.st)
            PS_D3C: begin
                if (main_pwr_ok) d.st = PS_D0U;
            end
            PS_D3H: begin
                if (!main_pwr_ok) d.st = PS_D3C;
                else if (pm_wr)   d.st = sel_st;
            end
            default: begin
                if (pm_wr)                         d.st = sel_st;
                else if (bar_wr && q.st == PS_D0U) d.st = PS_D0A;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q.st <= PS_D0U;
        else        q    <= d;
    end

    nic_pwr_wake u_wake (
        .clk     (clk),
        .rst_n   (rst_n),
        .state   (q.st),
        .link_chg(link_chg),
        .wake_pkt(wake_pkt),
        .aux_pwr (aux_pwr),
        .clr     (pm_wr && cfg_wdata[PME_CLR_BIT]),
        .pme_n   (pme_n)
    );

    nic_pwr_clkrun u_ckr (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (q.st == PS_D0A),
        .en_wr   (pm_wr),
        .en_val  (cfg_wdata[CKR_EN_BIT]),
        .stop_req(clk_stop_req),
        .busy    (link_busy),
        .clkrun_n(clkrun_n)
    );

    assign pwr_state = q.st;
    assign txn_en    = (q.st == PS_D0U) || (q.st == PS_D0A);
endmodule

// File: rtl/nic_pwr_ctl_chk.sv
module nic_pwr_ctl_chk #(
    parameter int CFG_AW      = 8,
    parameter int CFG_DW      = 8,
    parameter int BAR_BASE    = 'h10,
    parameter int PMCTL_ADDR  = 'h44,
    parameter int PME_CLR_BIT = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic [CFG_DW-1:0] cfg_wdata,
    input logic              link_chg,
    input logic              wake_pkt,
    input logic              aux_pwr,
    input logic              main_pwr_ok,
    input logic              clk_stop_req,
    input logic              link_busy,
    input logic [2:0]        pwr_state,
    input logic              txn_en,
    input logic              pme_n,
    input logic              clkrun_n
);
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pwr_state == 3'd0 && pme_n && clkrun_n));

    a_r2_bar_leaves_d0u: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 3'd0 && cfg_wr && cfg_addr == CFG_AW'(BAR_BASE)) |=> (pwr_state == 3'd1));

    a_r4_txn_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state >= 3'd2) |-> !txn_en);

    a_r5_power_loss: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 3'd4 && !main_pwr_ok) |=> (pwr_state == 3'd5));

    a_r7_link_in_d0a: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 3'd1 && link_chg) |=> !pme_n);

    a_r8_no_aux_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 3'd5 && !aux_pwr && pme_n) |=> pme_n);

    a_r9_pme_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!pme_n && !(cfg_wr && cfg_addr == CFG_AW'(PMCTL_ADDR) && cfg_wdata[PME_CLR_BIT]))
        |=> !pme_n);

    a_r10_clkrun_claim: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 3'd1 && clk_stop_req && link_busy) |=> !clkrun_n);
endmodule

bind nic_pwr_ctl nic_pwr_ctl_chk #(
    .CFG_AW(CFG_AW), .CFG_DW(CFG_DW), .BAR_BASE(BAR_BASE),
    .PMCTL_ADDR(PMCTL_ADDR), .PME_CLR_BIT(PME_CLR_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .link_chg(link_chg), .wake_pkt(wake_pkt),
    .aux_pwr(aux_pwr), .main_pwr_ok(main_pwr_ok), .clk_stop_req(clk_stop_req),
    .link_busy(link_busy), .pwr_state(pwr_state), .txn_en(txn_en),
    .pme_n(pme_n), .clkrun_n(clkrun_n)
);

// File: tb/nic_pwr_ctl_tb.sv
`timescale 1ns/1ps
module nic_pwr_ctl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       link_chg = 1'b0, wake_pkt = 1'b0, aux_pwr = 1'b0;
    logic       main_pwr_ok = 1'b1, clk_stop_req = 1'b0, link_busy = 1'b0;
    logic [2:0] pwr_state;
    logic       txn_en, pme_n, clkrun_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    nic_pwr_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .link_chg(link_chg), .wake_pkt(wake_pkt),
        .aux_pwr(aux_pwr), .main_pwr_ok(main_pwr_ok), .clk_stop_req(clk_stop_req),
        .link_busy(link_busy), .pwr_state(pwr_state), .txn_en(txn_en),
        .pme_n(pme_n), .clkrun_n(clkrun_n)
    );

    // behavioural reference model
    int m_st  = 0;
    bit m_pme = 1'b0;
    bit m_en  = 1'b1;
    bit m_ckr = 1'b0;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit acc, pm, bar, qual, wk;
        int ns;
        if (!rst_n) begin
            m_st <= 0; m_pme <= 1'b0; m_en <= 1'b1; m_ckr <= 1'b0;
        end else begin
            acc = cfg_wr && (m_st != 5);
            pm  = acc && (cfg_addr == 8'h44);
            bar = acc && (cfg_addr == 8'h10 || cfg_addr == 8'h14 || cfg_addr == 8'h18);
            ns  = m_st;
            if (m_st == 5) begin
                if (main_pwr_ok) ns = 0;
            end else if (m_st == 4 && !main_pwr_ok) begin
                ns = 5;
            end else if (pm) begin
                case (cfg_wdata[1:0])
                    2'd0:    ns = (m_st == 0) ? 0 : 1;
                    2'd1:    ns = 2;
                    2'd2:    ns = 3;
                    default: ns = 4;
                endcase
            end else if (bar && m_st == 0) begin
                ns = 1;
            end
            wk = link_chg || wake_pkt;
            case (m_st)
                0:       qual = 1'b0;
                1:       qual = link_chg;
                5:       qual = wk && aux_pwr;
                default: qual = wk;
            endcase
            if (qual)                    m_pme <= 1'b1;
            else if (pm && cfg_wdata[7]) m_pme <= 1'b0;
            if (pm) m_en <= cfg_wdata[2];
            m_ckr <= !m_en || (m_st == 1 && clk_stop_req && link_busy);
            m_st  <= ns;
        end
    end

    always @(posedge clk) begin
        #3;
        if (rst_n && !done) begin
            check("R3 state vs model", int'(pwr_state), m_st);
            check("R4 txn_en vs model", int'(txn_en), int'(m_st <= 1));
            check("R9 pme_n vs model", int'(pme_n), int'(!m_pme));
            check("R10 clkrun_n vs model", int'(clkrun_n), int'(!m_ckr));
        end
    end

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] dv);
        @(negedge clk); cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = dv;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic pulse(input bit lc, input bit wp);
        @(negedge clk); link_chg = lc; wake_pkt = wp;
        @(negedge clk); link_chg = 1'b0; wake_pkt = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 state in reset", int'(pwr_state), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 state", int'(pwr_state), 0);
        check("R1 txn_en", int'(txn_en), 1);
        check("R1 pme_n", int'(pme_n), 1);
        check("R1 clkrun_n", int'(clkrun_n), 1);

        cfg_write(8'h20, 8'h00);
        check("R2 other address keeps D0u", int'(pwr_state), 0);
        cfg_write(8'h44, 8'h04);
        check("R3 select 00 from D0u", int'(pwr_state), 0);
        pulse(1'b1, 1'b1);
        check("R7 no wake in D0u", int'(pme_n), 1);
        check("R4 txn_en in D0u", int'(txn_en), 1);

        cfg_write(8'h14, 8'hAA);
        check("R2 BAR write to D0a", int'(pwr_state), 1);
        pulse(1'b0, 1'b1);
        check("R7 packet ignored in D0a", int'(pme_n), 1);
        pulse(1'b1, 1'b0);
        check("R7 link change in D0a", int'(pme_n), 0);
        cfg_write(8'h44, 8'h04);
        check("R9 no clear without bit7", int'(pme_n), 0);
        @(negedge clk); cfg_wr = 1'b1; cfg_addr = 8'h44; cfg_wdata = 8'h84; link_chg = 1'b1;
        @(negedge clk); cfg_wr = 1'b0; link_chg = 1'b0;
        check("R9 set wins over clear", int'(pme_n), 0);
        cfg_write(8'h44, 8'h84);
        check("R9 clear", int'(pme_n), 1);

        clk_stop_req = 1'b1;
        @(negedge clk);
        check("R10 idle no claim", int'(clkrun_n), 1);
        link_busy = 1'b1;
        @(negedge clk);
        check("R10 busy claims clock", int'(clkrun_n), 0);
        clk_stop_req = 1'b0;
        @(negedge clk);
        check("R10 release", int'(clkrun_n), 1);
        clk_stop_req = 1'b1;

        cfg_write(8'h44, 8'h05);
        check("R3 to D1", int'(pwr_state), 2);
        check("R4 txn off in D1", int'(txn_en), 0);
        @(negedge clk);
        check("R10 no claim in D1", int'(clkrun_n), 1);
        clk_stop_req = 1'b0; link_busy = 1'b0;
        pulse(1'b0, 1'b1);
        check("R6 packet wake in D1", int'(pme_n), 0);
        cfg_write(8'h44, 8'h86);
        check("R3 to D2", int'(pwr_state), 3);
        check("R9 cleared", int'(pme_n), 1);
        pulse(1'b1, 1'b0);
        check("R6 link wake in D2", int'(pme_n), 0);
        cfg_write(8'h44, 8'h87);
        check("R3 to D3hot", int'(pwr_state), 4);
        pulse(1'b0, 1'b1);
        check("R6 packet wake in D3hot", int'(pme_n), 0);
        cfg_write(8'h44, 8'h87);
        check("R9 clear in D3hot", int'(pme_n), 1);

        @(negedge clk); main_pwr_ok = 1'b0;
        @(negedge clk);
        check("R5 power loss to D3cold", int'(pwr_state), 5);
        cfg_write(8'h44, 8'h04);
        check("R5 write ignored in D3cold", int'(pwr_state), 5);
        pulse(1'b0, 1'b1);
        check("R8 no wake without aux", int'(pme_n), 1);
        aux_pwr = 1'b1;
        pulse(1'b0, 1'b1);
        check("R8 wake with aux", int'(pme_n), 0);
        @(negedge clk); main_pwr_ok = 1'b1;
        @(negedge clk);
        check("R5 power return to D0u", int'(pwr_state), 0);
        check("R9 pme kept across D0 return", int'(pme_n), 0);
        cfg_write(8'h44, 8'h84);
        check("R9 clear after return", int'(pme_n), 1);

        cfg_write(8'h18, 8'h00);
        check("R2 third BAR", int'(pwr_state), 1);
        cfg_write(8'h44, 8'h00);
        @(negedge clk);
        check("R11 clock claimed when disabled", int'(clkrun_n), 0);
        cfg_write(8'h44, 8'h01);
        check("R11 still claimed in D1", int'(clkrun_n), 0);
        cfg_write(8'h44, 8'h04);
        @(negedge clk);
        check("R11 re-enabled releases", int'(clkrun_n), 1);
        check("R3 D1 back to D0a", int'(pwr_state), 1);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule